// File: doc/BRIEF.md
# Timer-Triggered Sample Sequencer FIFO Controller

This block is the digital side of a converter front end. It holds several sample sequencers, and each sequencer has its own small result FIFO. A trigger input, usually pulsed by a general-purpose timer, offers one sample to every sequencer that is switched on and whose event selector picks the timer. The block has no real converter data, so each sample comes from a pseudo-random noise register. Each sample that a trigger offers raises that sequencer's raw interrupt bit. Each interrupt output is the raw bit gated by a mask bit.

Software reaches the block through a simple register port with a write strobe, a read strobe and combinational read data. Reading a sequencer's data register pops its FIFO. A separate status register reports the read pointer, the write pointer, an empty flag and a full flag, all packed into one word, so software can poll the FIFO without side effects.

Top module: `smpseq_fifo_ctrl`

## Requirements
- R1: After reset, every sequencer status word reads 0x100 (empty only). The enable register reads 0, the raw status reads 0, all interrupt outputs are low, and the noise register is 0.
- R2: A sample accepted into a sequencer is written at the write pointer, and the write pointer then advances modulo 16. The empty flag clears. Full sets when the new write pointer equals the read pointer. The status word holds the read pointer in bits 3:0, the write pointer in bits 7:4, empty in bit 8 and full in bit 12.
- R3: A sample offered to a full FIFO is dropped. The pointers, the flags and the stored data stay unchanged.
- R4: A read strobe at sequencer offset 0x08 returns the oldest entry. The read pointer then advances modulo 16, full clears, and empty sets when the new read pointer equals the write pointer. Data comes out in the order it was written.
- R5: Popping an empty FIFO changes neither its pointers nor its flags.
- R6: A trigger services sequencer n only when enable bit n is set and the 4-bit event field at bits 4n+3:4n of register 0x14 equals 5. Every other sequencer is left untouched.
- R7: Interrupt output n is high exactly when raw bit n and mask bit n are both set. Register 0x04 reads the raw bits, 0x08 the mask bits, and 0x0C the raw bits AND the mask bits.
- R8: Writing ones to 0x0C clears those raw bits. A service in the same cycle sets its bit anyway, and the set wins.
- R9: The per-sequencer registers sit at 0x40 + 0x20*n. The input-select register at +0x00 keeps only the bits of 0x33333333. The control register at +0x04 keeps all 32 bits. Status is at +0x0C.
- R10: The enable register at 0x00 keeps only its 4 low bits.
- R11: Before each serviced sequencer takes its sample, the noise register steps to noise*314159+1 (mod 2^32). Sequencers are handled in ascending order within one trigger, and the sample is 0x200 plus noise bits 18:16. The noise also steps when the sample is then dropped because the FIFO is full.
- R12: A pop and an accepted push to the same sequencer in one cycle advance both pointers and leave the flags unchanged. When the FIFO is empty, only the push takes effect. When it is full, only the pop takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at data offsets) |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data |
| trig | input | 1 | Sample trigger, one event per high cycle |
| irq | output | 4 | Per-sequencer masked interrupt |

## Verification
The bench builds the block with its default parameters: four sequencers, 16-entry FIFOs and 4-bit event fields. At this size every pointer value and both flag transitions can be reached with a few dozen triggers. It drives each FIFO from empty to full and then back to empty, checking all four status words after every step. Its own arithmetic noise model predicts every popped value. That model also covers gated and dropped samples, the ordering within one trigger, and a pop that coincides with a push.

// File: rtl/smpseq_pkg.sv
package smpseq_pkg;
   localparam int REG_W        = 32;
   localparam int SEQ_BASE     = 'h40;
   localparam int SEQ_STRIDE_L = 5;        // 0x20 per sequencer
   localparam int A_ENABLE     = 'h00;
   localparam int A_RAW        = 'h04;
   localparam int A_MASK       = 'h08;
   localparam int A_MSTAT      = 'h0C;
   localparam int A_EVSEL      = 'h14;
   localparam int O_INSEL      = 'h00;
   localparam int O_CTRL       = 'h04;
   localparam int O_DATA       = 'h08;
   localparam int O_STAT       = 'h0C;
   localparam logic [REG_W-1:0] INSEL_KEEP = 32'h3333_3333;
   localparam logic [REG_W-1:0] NOISE_MUL  = 32'd314159;
   localparam int STAT_HEAD_LSB = 4;
   localparam int STAT_EMPTY    = 8;
   localparam int STAT_FULL     = 12;
endpackage

// File: rtl/smpseq_fifo.sv
module smpseq_fifo
   import smpseq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int DW    = 12,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [DW-1:0]     din,
   output logic [DW-1:0]     dout,
   output logic [REG_W-1:0]  stat
);
   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] head_q, tail_q;
   logic          empty_q, full_q;
   logic          push_ok, pop_ok;
   logic [PW-1:0] head_inc, tail_inc;

   assign push_ok  = push && !full_q;
   assign pop_ok   = pop && !empty_q;
   assign head_inc = head_q + PW'(1);
   assign tail_inc = tail_q + PW'(1);

   always_ff @(posedge clk) begin
      if (push_ok) mem[head_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q  <= '0;
         tail_q  <= '0;
         empty_q <= 1'b1;
         full_q  <= 1'b0;
      end else begin
         if (push_ok) head_q <= head_inc;
         if (pop_ok)  tail_q <= tail_inc;
         if (push_ok && !pop_ok) begin
            empty_q <= 1'b0;
            full_q  <= (head_inc == tail_q);
         end else if (pop_ok && !push_ok) begin
            full_q  <= 1'b0;
            empty_q <= (tail_inc == head_q);
         end
      end
   end

   assign dout = mem[tail_q];

   always_comb begin
      stat = '0;
      stat[PW-1:0]                 = tail_q;
      stat[STAT_HEAD_LSB +: PW]    = head_q;
      stat[STAT_EMPTY]             = empty_q;
      stat[STAT_FULL]              = full_q;
   end
endmodule

// File: rtl/smpseq_noise.sv
module smpseq_noise
   import smpseq_pkg::*;
#(
   parameter int NUM_SEQ = 4,
   parameter int DW      = 12
) (
   input  logic [REG_W-1:0]      noise_q,
   input  logic [NUM_SEQ-1:0]    svc,
   output logic [NUM_SEQ*DW-1:0] samples,
   output logic [REG_W-1:0]      noise_d
);
   logic [REG_W-1:0] chain [NUM_SEQ+1];
   assign chain[0] = noise_q;

   for (genvar n = 0; n < NUM_SEQ; n++) begin : g_step
      logic [REG_W-1:0] nxt;
      assign nxt = chain[n] * NOISE_MUL + REG_W'(1);
      assign chain[n+1] = svc[n] ? nxt : chain[n];
      assign samples[n*DW +: DW] = DW'(10'h200) + DW'(nxt[18:16]);
   end

   assign noise_d = chain[NUM_SEQ];
endmodule

// File: rtl/smpseq_fifo_ctrl.sv
module smpseq_fifo_ctrl
   import smpseq_pkg::*;
#(
   parameter int NUM_SEQ    = 4,
   parameter int FIFO_DEPTH = 16,
   parameter int SMP_W      = 12,
   parameter int ADDR_W     = 12,
   parameter int EVT_W      = 4,
   parameter int TIMER_EVT  = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   input  logic                trig,
   output logic [NUM_SEQ-1:0]  irq
);
   localparam int BLK_W    = ADDR_W - SEQ_STRIDE_L;
   localparam int BASE_BLK = SEQ_BASE >> SEQ_STRIDE_L;

   if (NUM_SEQ < 1 || NUM_SEQ * EVT_W > REG_W)
      $error("NUM_SEQ event fields must fit one register");
   if (FIFO_DEPTH < 2 || FIFO_DEPTH > 16 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0)
      $error("FIFO_DEPTH must be a power of two from 2 to 16");
   if (SMP_W < 10 || SMP_W > REG_W)
      $error("SMP_W must hold the sample range");
   if ((1 << ADDR_W) < SEQ_BASE + (NUM_SEQ << SEQ_STRIDE_L))
      $error("ADDR_W too small for the sequencer window");
   if (TIMER_EVT >= (1 << EVT_W))
      $error("TIMER_EVT does not fit an event field");

   logic [NUM_SEQ-1:0] act_q, im_q, ris_q;
   logic [REG_W-1:0]   emux_q, noise_q, noise_d;
   logic [REG_W-1:0]   insel_q [NUM_SEQ];
   logic [REG_W-1:0]   ctrl_q  [NUM_SEQ];
   logic [NUM_SEQ-1:0] svc, push, pop;
   logic [NUM_SEQ*SMP_W-1:0] samples;
   logic [SMP_W-1:0]   dout [NUM_SEQ];
   logic [REG_W-1:0]   stat [NUM_SEQ];
   logic [NUM_SEQ*REG_W-1:0] stat_flat;

   // address decode
   logic               glb_hit, seq_hit;
   logic [BLK_W-1:0]   seq_blk;
   logic [4:0]         seq_off;
   assign seq_off = reg_addr[4:0];
   assign seq_blk = reg_addr[ADDR_W-1:SEQ_STRIDE_L] - BLK_W'(BASE_BLK);
   assign seq_hit = (reg_addr[ADDR_W-1:SEQ_STRIDE_L] >= BLK_W'(BASE_BLK)) &&
                    (seq_blk < BLK_W'(NUM_SEQ));
   assign glb_hit = (reg_addr[ADDR_W-1:SEQ_STRIDE_L] < BLK_W'(BASE_BLK));

   for (genvar n = 0; n < NUM_SEQ; n++) begin : g_seq
      assign svc[n]  = act_q[n] && (emux_q[EVT_W*n +: EVT_W] == EVT_W'(TIMER_EVT));
      assign push[n] = trig && svc[n];
      assign pop[n]  = reg_rd && seq_hit && (seq_blk == BLK_W'(n)) &&
                       (seq_off == 5'(O_DATA));
      assign stat_flat[n*REG_W +: REG_W] = stat[n];

      smpseq_fifo #(.DEPTH(FIFO_DEPTH), .DW(SMP_W)) u_fifo (
         .clk  (clk),
         .rst_n(rst_n),
         .push (push[n]),
         .pop  (pop[n]),
         .din  (samples[n*SMP_W +: SMP_W]),
         .dout (dout[n]),
         .stat (stat[n])
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            insel_q[n] <= '0;
            ctrl_q[n]  <= '0;
         end else if (reg_wr && seq_hit && seq_blk == BLK_W'(n)) begin
            if (seq_off == 5'(O_INSEL)) insel_q[n] <= reg_wdata & INSEL_KEEP;
            if (seq_off == 5'(O_CTRL))  ctrl_q[n]  <= reg_wdata;
         end
      end
   end

   smpseq_noise #(.NUM_SEQ(NUM_SEQ), .DW(SMP_W)) u_noise (
      .noise_q(noise_q),
      .svc    (push),
      .samples(samples),
      .noise_d(noise_d)
   );

   logic gw;
   assign gw = reg_wr && glb_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q   <= '0;
         im_q    <= '0;
         ris_q   <= '0;
         emux_q  <= '0;
         noise_q <= '0;
      end else begin
         noise_q <= noise_d;
         if (gw && reg_addr[4:0] == 5'(A_ENABLE)) act_q  <= reg_wdata[NUM_SEQ-1:0];
         if (gw && reg_addr[4:0] == 5'(A_MASK))   im_q   <= reg_wdata[NUM_SEQ-1:0];
         if (gw && reg_addr[4:0] == 5'(A_EVSEL))  emux_q <= reg_wdata;
         if (gw && reg_addr[4:0] == 5'(A_MSTAT))
            ris_q <= (ris_q & ~reg_wdata[NUM_SEQ-1:0]) | push;
         else
            ris_q <= ris_q | push;
      end
   end

   assign irq = ris_q & im_q;

   always_comb begin
      reg_rdata = '0;
      if (glb_hit) begin
         case (reg_addr[4:0])
            5'(A_ENABLE): reg_rdata = REG_W'(act_q);
            5'(A_RAW):    reg_rdata = REG_W'(ris_q);
            5'(A_MASK):   reg_rdata = REG_W'(im_q);
            5'(A_MSTAT):  reg_rdata = REG_W'(ris_q & im_q);
            5'(A_EVSEL):  reg_rdata = emux_q;
            default:      reg_rdata = '0;
         endcase
      end
      for (int n = 0; n < NUM_SEQ; n++) begin
         if (seq_hit && seq_blk == BLK_W'(n)) begin
            case (seq_off)
               5'(O_INSEL): reg_rdata = insel_q[n];
               5'(O_CTRL):  reg_rdata = ctrl_q[n];
               5'(O_DATA):  reg_rdata = REG_W'(dout[n]);
               5'(O_STAT):  reg_rdata = stat[n];
               default:     reg_rdata = '0;
            endcase
         end
      end
   end
endmodule

// File: rtl/smpseq_chk.sv
module smpseq_chk
   import smpseq_pkg::*;
#(
   parameter int NUM_SEQ   = 4,
   parameter int EVT_W     = 4,
   parameter int TIMER_EVT = 5
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     trig,
   input logic                     reg_rd,
   input logic [NUM_SEQ-1:0]       irq,
   input logic [NUM_SEQ-1:0]       act_q,
   input logic [NUM_SEQ-1:0]       im_q,
   input logic [NUM_SEQ-1:0]       ris_q,
   input logic [REG_W-1:0]         emux_q,
   input logic [NUM_SEQ*REG_W-1:0] stat_flat
);
   for (genvar n = 0; n < NUM_SEQ; n++) begin : g_chk
      logic em, fu;
      logic [3:0] tl, hd;
      logic sv;
      assign em = stat_flat[n*REG_W + STAT_EMPTY];
      assign fu = stat_flat[n*REG_W + STAT_FULL];
      assign tl = stat_flat[n*REG_W +: 4];
      assign hd = stat_flat[n*REG_W + STAT_HEAD_LSB +: 4];
      assign sv = act_q[n] && (emux_q[EVT_W*n +: EVT_W] == EVT_W'(TIMER_EVT));

      AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
         !(em && fu)); // R2
      AST_FULL_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
         fu |-> (hd == tl)); // R2
      AST_EMPTY_PTRS: assert property (@(posedge clk) disable iff (!rst_n)
         em |-> (hd == tl)); // R4
      AST_SERVICE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
         (trig && sv) |=> !em); // R6
      AST_SERVICE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
         (trig && sv) |=> ris_q[n]); // R8
      AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
         irq[n] |-> im_q[n]); // R7
   end

   AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig && !reg_rd) |=> $stable(stat_flat)); // R5
endmodule

bind smpseq_fifo_ctrl smpseq_chk #(
   .NUM_SEQ(NUM_SEQ), .EVT_W(EVT_W), .TIMER_EVT(TIMER_EVT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .trig(trig), .reg_rd(reg_rd), .irq(irq),
   .act_q(act_q), .im_q(im_q), .ris_q(ris_q), .emux_q(emux_q),
   .stat_flat(stat_flat)
);

// File: tb/smpseq_fifo_ctrl_tb.sv
module smpseq_fifo_ctrl_tb;
   logic        clk = 0, rst_n = 0;
   logic        reg_wr = 0, reg_rd = 0, trig = 0;
   logic [11:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic [3:0]  irq;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   smpseq_fifo_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .trig(trig), .irq(irq)
   );

   always #5 clk = ~clk;

   // reference model
   logic [31:0] m_noise = 0;
   logic [11:0] m_mem [4][16];
   int          m_hd[4], m_tl[4], m_cnt[4];
   logic [3:0]  m_act = 0, m_ris = 0;
   logic [31:0] m_emux = 0;

   function automatic logic [31:0] exp_stat(int n);
      return 32'(m_tl[n]) | (32'(m_hd[n]) << 4) |
             ((m_cnt[n] == 0) ? 32'h100 : 0) | ((m_cnt[n] == 16) ? 32'h1000 : 0);
   endfunction

   task automatic model_trig();
      for (int n = 0; n < 4; n++) begin
         if (m_act[n] && m_emux[4*n +: 4] == 4'd5) begin
            m_noise = m_noise * 32'd314159 + 32'd1;
            m_ris[n] = 1'b1;
            if (m_cnt[n] < 16) begin
               m_mem[n][m_hd[n]] = 12'h200 + 12'((m_noise >> 16) & 7);
               m_hd[n] = (m_hd[n] + 1) % 16;
               m_cnt[n]++;
            end
         end
      end
   endtask

   task automatic model_pop(int n, output logic [31:0] d);
      d = 32'(m_mem[n][m_tl[n]]);
      if (m_cnt[n] > 0) begin
         m_tl[n] = (m_tl[n] + 1) % 16;
         m_cnt[n]--;
      end
   endtask

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      tick();
      reg_wr = 0;
   endtask

   task automatic rd(logic [11:0] a, output logic [31:0] d);
      reg_rd = 1; reg_addr = a;
      #1 d = reg_rdata;
      tick();
      reg_rd = 0;
   endtask

   task automatic fire();
      trig = 1;
      tick();
      trig = 0;
      model_trig();
   endtask

   function automatic logic [11:0] sa(int n, int off);
      return 12'(32'h40 + 32'h20 * n + off);
   endfunction

   task automatic check_all_stat(string req);
      logic [31:0] d;
      for (int n = 0; n < 4; n++) begin
         rd(sa(n, 'h0C), d);
         check(req, d, exp_stat(n));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d, e;
      for (int n = 0; n < 4; n++) begin m_hd[n] = 0; m_tl[n] = 0; m_cnt[n] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      check_all_stat("R1");
      check("R1", 32'(irq), 0);
      rd(12'h000, d); check("R1", d, 0);
      rd(12'h004, d); check("R1", d, 0);

      // R9 per-sequencer registers
      wr(sa(1, 0), 32'hFFFF_FFFF); rd(sa(1, 0), d); check("R9", d, 32'h3333_3333);
      wr(sa(3, 4), 32'hA5C3_0F96); rd(sa(3, 4), d); check("R9", d, 32'hA5C3_0F96);
      rd(sa(0, 0), d); check("R9", d, 0);

      // R10 enable width
      wr(12'h000, 32'hFFFF_FFFF); m_act = 4'hF;
      rd(12'h000, d); check("R10", d, 32'hF);

      // R7 masking, R11 first samples
      wr(12'h014, 32'h0000_5555); m_emux = 32'h5555;
      fire();
      rd(12'h004, d); check("R7", d, 32'hF);
      check("R7", 32'(irq), 0);
      wr(12'h008, 32'h5);
      check("R7", 32'(irq), 32'h5);
      rd(12'h00C, d); check("R7", d, 32'h5);

      // R8 write-one-to-clear, and set wins over clear
      wr(12'h00C, 32'h3); m_ris = m_ris & ~4'h3;
      rd(12'h004, d); check("R8", d, 32'(m_ris));
      check("R8", 32'(irq), 32'h4);
      reg_wr = 1; reg_addr = 12'h00C; reg_wdata = 32'hF; trig = 1;
      tick();
      reg_wr = 0; trig = 0; m_ris = 0; model_trig();
      rd(12'h004, d); check("R8", d, 32'hF);
      wr(12'h008, 32'hF);

      // R2 fill sweep
      check_all_stat("R2");
      while (m_cnt[0] < 16) begin
         fire();
         check_all_stat("R2");
      end

      // R3 push into full
      fire();
      check_all_stat("R3");

      // R4 / R11 drain sequencer 0 and half of 1
      for (int i = 0; i < 16; i++) begin
         model_pop(0, e); rd(sa(0, 8), d); check("R11", d, e);
         rd(sa(0, 'h0C), d); check("R4", d, exp_stat(0));
      end
      for (int i = 0; i < 8; i++) begin
         model_pop(1, e); rd(sa(1, 8), d); check("R4", d, e);
      end
      check_all_stat("R4");

      // R5 pop empty
      rd(sa(0, 8), d);
      rd(sa(0, 'h0C), d); check("R5", d, exp_stat(0));

      // R6 gating: seq2 disabled, seq1 wrong event
      wr(12'h000, 32'hB); m_act = 4'hB;
      wr(12'h014, 32'h0000_5545); m_emux = 32'h5545;
      for (int i = 0; i < 3; i++) begin
         fire();
         check_all_stat("R6");
      end
      for (int i = 0; i < 2; i++) begin
         model_pop(1, e); rd(sa(1, 8), d); check("R6", d, e);
      end

      // R12 simultaneous push and pop on seq0, then pop on empty with push
      reg_rd = 1; reg_addr = sa(0, 8); trig = 1;
      #1 d = reg_rdata;
      tick();
      reg_rd = 0; trig = 0;
      model_pop(0, e); check("R12", d, e); model_trig();
      check_all_stat("R12");
      while (m_cnt[0] > 0) begin
         model_pop(0, e); rd(sa(0, 8), d); check("R12", d, e);
      end
      reg_rd = 1; reg_addr = sa(0, 8); trig = 1;
      tick();
      reg_rd = 0; trig = 0; model_trig();
      check_all_stat("R12");
      model_pop(0, e); rd(sa(0, 8), d); check("R12", d, e);
      check_all_stat("R12");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule